// File: doc/BRIEF.md
# Flash Identification Probe for a Four-Lane Parallel Bus

This block runs once after power-up to find out what is attached to a 32-bit parallel memory bus made of four byte-wide devices side by side. On a start pulse it takes over a simple synchronous bus master port and runs these steps in order:

- It reads and keeps the word at address 0.
- It writes the identifier command with the same byte on every lane.
- It reads the manufacturer word at byte address 0 and the device word at byte address 4.

From these reads it reports one of four results: a known flash with its total capacity and erase-block size, a flash from the expected maker whose device code is not in the table, RAM, or nothing recognised.

Flash is told apart from RAM by the readback of address 0. A flash in identifier mode returns its maker code. A RAM returns the command word that was just written into it. In the RAM case the probe writes the saved word back, so the memory is left as it was. In either flash case the probe ends by writing the read-array command, so the flash leaves identifier mode. The done output pulses for one cycle when the probe has finished. The result and both sizes are valid in that cycle and stay unchanged until the next start.

Top module: `fl_id_probe`

## Requirements
- R1: While reset is held and after it is released, done, busy, bus_rd and bus_wr are 0 and result is 0 (none).
- R2: After start, the first bus operation is a read of byte address 0. The second is a write of 0x90909090 to byte address 0.
- R3: The third operation reads the manufacturer word at byte address 0. The fourth reads the device word at byte address 4.
- R4: If the manufacturer word is 0x89898989 and the device word is 0xAAAAAAAA or 0xA0A0A0A0, the result is 1 (known flash), total_size is 0x00800000 and erase_size is 0x00040000.
- R5: If the manufacturer word is 0x89898989 and the device word is 0xA6A6A6A6, the result is 1, total_size is 0x00400000 and erase_size is 0x00040000.
- R6: If the manufacturer word is 0x89898989 and the device word is any other value, the result is 2 (unknown flash) and total_size and erase_size are both 0.
- R7: When the result is 1 or 2, the fifth and last operation of the run writes 0xFFFFFFFF to byte address 0.
- R8: If the manufacturer word is not 0x89898989, address 0 is read a second time. If that read returns 0x90909090, the result is 3 (RAM). The sixth and last operation then writes the word saved by the first read back to address 0, and no read-array command is issued.
- R9: If the manufacturer word is not 0x89898989 and the second read of address 0 is not 0x90909090, the result is 0 (none). The run ends after that read, so the identifier command is the only write of the run. A word that differs from 0x89898989 in a single lane counts as a mismatch.
- R10: bus_rd and bus_wr are never high together. A strobe, bus_addr and, for writes, bus_wdata stay unchanged until bus_ready is sampled high. The strobe drops in the next cycle.
- R11: done is high for exactly one cycle per run, and result and sizes are valid in that cycle. A start pulse while busy is high is ignored and does not launch a second run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a probe; sampled only while idle |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle pulse at the end of a probe |
| result | output | 2 | 0 none, 1 known flash, 2 unknown flash, 3 RAM |
| total_size | output | 32 | Capacity in bytes of the whole bus (0 unless known flash) |
| erase_size | output | 32 | Erase-block size in bytes across all lanes (0 unless known flash) |
| bus_addr | output | 24 | Byte address of the current transfer |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid while bus_ready is high |
| bus_rd | output | 1 | Read strobe, held until bus_ready |
| bus_wr | output | 1 | Write strobe, held until bus_ready |
| bus_ready | input | 1 | Transfer completes in a cycle where this is high |

## Verification
The bench attaches the probe to a behavioural device that can act as a flash with an identifier mode, as a RAM, or as a fixed-pattern ROM. It records every completed transfer. The corner cases it targets are these:

- A RAM readback. A design that skipped the restore would leave the command word in memory. A design that sent a read-array write instead would overwrite the RAM with ones.
- A maker code wrong in only one lane. A design that compared only the low byte would report a flash.
- An unknown device code. A design that did not zero the sizes would report a stale capacity.
- A start pulse in the middle of a run, under bus wait states. A design that re-armed on it would issue a second sequence of transfers. One that did not hold its strobe would drop transfers.

// File: rtl/flprobe_pkg.sv
// Package: flprobe_pkg
// Shared result encoding and sequencer state type for the identification
// probe. Assumes a single-clock design with synchronous reset.
package flprobe_pkg;

    typedef enum logic [1:0] {
        RES_NONE          = 2'd0,
        RES_FLASH_KNOWN   = 2'd1,
        RES_FLASH_UNKNOWN = 2'd2,
        RES_RAM           = 2'd3
    } probe_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_CMD_ID,
        ST_RD_MFR,
        ST_RD_DEV,
        ST_RECHECK,
        ST_RESTORE,
        ST_RESET_ARR
    } seq_st_e;

endpackage

// File: rtl/flprobe_bus_master.sv
// Module: flprobe_bus_master
// Runs one bus transfer at a time. Accepts a request only while idle,
// holds strobe, address and data until bus_ready is seen high, then
// pulses cmd_ack for one cycle with the captured read data.
// Assumes the requester keeps cmd_valid low while a transfer is running.
module flprobe_bus_master #(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ack,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_rd,
    output logic          bus_wr,
    input  logic          bus_ready
);

    logic active;
    assign active = bus_rd | bus_wr;

    // Transfer engine: launch, hold until ready, then acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            cmd_ack   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            cmd_ack <= 1'b0;
            if (active) begin
                if (bus_ready) begin
                    bus_rd  <= 1'b0;
                    bus_wr  <= 1'b0;
                    cmd_ack <= 1'b1;
                    if (bus_rd) begin
                        rsp_data <= bus_rdata;
                    end
                end
            end else if (cmd_valid) begin
                bus_rd    <= ~cmd_write;
                bus_wr    <= cmd_write;
                bus_addr  <= cmd_addr;
                bus_wdata <= cmd_wdata;
            end
        end
    end

endmodule

// File: rtl/flprobe_id_decode.sv
// Module: flprobe_id_decode
// Combinational lookup of the maker and device words. A word matches only
// when the code byte is repeated on every lane. Sizes are per-lane values
// multiplied by the lane count, and are forced to zero unless the device
// is known.
module flprobe_id_decode #(
    parameter int          DW               = 32,
    parameter int          SZW              = 32,
    parameter logic [7:0]  MFR_CODE         = 8'h89,
    parameter logic [7:0]  DEV_BIG_A        = 8'hAA,
    parameter logic [7:0]  DEV_BIG_B        = 8'hA0,
    parameter logic [7:0]  DEV_SMALL        = 8'hA6,
    parameter int unsigned LANE_BIG_BYTES   = 32'h0020_0000,
    parameter int unsigned LANE_SMALL_BYTES = 32'h0010_0000,
    parameter int unsigned LANE_BLOCK_BYTES = 32'h0001_0000
) (
    input  logic [DW-1:0]  mfr_word,
    input  logic [DW-1:0]  dev_word,
    output logic           mfr_ok,
    output logic           dev_known,
    output logic [SZW-1:0] total_bytes,
    output logic [SZW-1:0] erase_bytes
);

    localparam int LANES = DW / 8;
    localparam logic [DW-1:0]  MFR_WORD    = {LANES{MFR_CODE}};
    localparam logic [DW-1:0]  BIG_A_WORD  = {LANES{DEV_BIG_A}};
    localparam logic [DW-1:0]  BIG_B_WORD  = {LANES{DEV_BIG_B}};
    localparam logic [DW-1:0]  SMALL_WORD  = {LANES{DEV_SMALL}};
    localparam logic [SZW-1:0] BIG_TOTAL   = SZW'(LANE_BIG_BYTES * LANES);
    localparam logic [SZW-1:0] SMALL_TOTAL = SZW'(LANE_SMALL_BYTES * LANES);
    localparam logic [SZW-1:0] BLOCK_TOTAL = SZW'(LANE_BLOCK_BYTES * LANES);

    logic is_big;
    logic is_small;

    // Classify the device word and select the geometry.
    always_comb begin
        mfr_ok      = (mfr_word == MFR_WORD);
        is_big      = (dev_word == BIG_A_WORD) || (dev_word == BIG_B_WORD);
        is_small    = (dev_word == SMALL_WORD);
        dev_known   = mfr_ok && (is_big || is_small);
        total_bytes = '0;
        erase_bytes = '0;
        if (dev_known) begin
            total_bytes = is_big ? BIG_TOTAL : SMALL_TOTAL;
            erase_bytes = BLOCK_TOTAL;
        end
    end

endmodule

// File: rtl/flprobe_seq.sv
// Module: flprobe_seq
// Step sequencer of the probe. Issues one request per state to the bus
// master and advances on its acknowledge. The result registers are cleared
// on start and loaded when the outcome is known. done pulses on the final
// acknowledge. Assumes ack comes only for a request this block issued.
module flprobe_seq
    import flprobe_pkg::*;
#(
    parameter int         AW          = 24,
    parameter int         DW          = 32,
    parameter int         SZW         = 32,
    parameter logic [7:0] CMD_READ_ID = 8'h90,
    parameter logic [7:0] CMD_ARRAY   = 8'hFF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output probe_res_e     result,
    output logic [SZW-1:0] total_size,
    output logic [SZW-1:0] erase_size,
    output logic           cmd_valid,
    output logic           cmd_write,
    output logic [AW-1:0]  cmd_addr,
    output logic [DW-1:0]  cmd_wdata,
    input  logic           cmd_ack,
    input  logic [DW-1:0]  rsp_data,
    output logic [DW-1:0]  mfr_word,
    input  logic           mfr_ok,
    input  logic           dev_known,
    input  logic [SZW-1:0] dec_total,
    input  logic [SZW-1:0] dec_erase
);

    localparam int LANES = DW / 8;
    localparam logic [DW-1:0] ID_WORD    = {LANES{CMD_READ_ID}};
    localparam logic [DW-1:0] ARRAY_WORD = {LANES{CMD_ARRAY}};
    localparam logic [AW-1:0] DEV_ADDR   = AW'(LANES);

    seq_st_e       state;
    logic          pend;
    logic [DW-1:0] saved;

    assign busy = (state != ST_IDLE);

    // Request generation: one transfer per state, issued while none pending.
    always_comb begin
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        if (!pend) begin
            unique case (state)
                ST_SAVE, ST_RD_MFR, ST_RECHECK: cmd_valid = 1'b1;
                ST_RD_DEV: begin
                    cmd_valid = 1'b1;
                    cmd_addr  = DEV_ADDR;
                end
                ST_CMD_ID: begin
                    cmd_valid = 1'b1;
                    cmd_write = 1'b1;
                    cmd_wdata = ID_WORD;
                end
                ST_RESTORE: begin
                    cmd_valid = 1'b1;
                    cmd_write = 1'b1;
                    cmd_wdata = saved;
                end
                ST_RESET_ARR: begin
                    cmd_valid = 1'b1;
                    cmd_write = 1'b1;
                    cmd_wdata = ARRAY_WORD;
                end
                default: cmd_valid = 1'b0;
            endcase
        end
    end

    // State, pending flag, captured words and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pend       <= 1'b0;
            saved      <= '0;
            mfr_word   <= '0;
            done       <= 1'b0;
            result     <= RES_NONE;
            total_size <= '0;
            erase_size <= '0;
        end else begin
            done <= 1'b0;
            if (cmd_valid) pend <= 1'b1;
            if (cmd_ack)   pend <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_SAVE;
                    result     <= RES_NONE;
                    total_size <= '0;
                    erase_size <= '0;
                end
                ST_SAVE: if (cmd_ack) begin
                    saved <= rsp_data;
                    state <= ST_CMD_ID;
                end
                ST_CMD_ID: if (cmd_ack) state <= ST_RD_MFR;
                ST_RD_MFR: if (cmd_ack) begin
                    mfr_word <= rsp_data;
                    state    <= ST_RD_DEV;
                end
                ST_RD_DEV: if (cmd_ack) begin
                    if (mfr_ok) begin
                        result     <= dev_known ? RES_FLASH_KNOWN : RES_FLASH_UNKNOWN;
                        total_size <= dec_total;
                        erase_size <= dec_erase;
                        state      <= ST_RESET_ARR;
                    end else begin
                        state <= ST_RECHECK;
                    end
                end
                ST_RECHECK: if (cmd_ack) begin
                    if (rsp_data == ID_WORD) begin
                        result <= RES_RAM;
                        state  <= ST_RESTORE;
                    end else begin
                        result <= RES_NONE;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_RESTORE, ST_RESET_ARR: if (cmd_ack) begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fl_id_probe.sv
// Module: fl_id_probe
// Top of the identification probe. Joins the sequencer, the bus transfer
// engine and the code decoder. The device word is decoded straight from
// the read response, in the acknowledge cycle of the device read.
// Assumes the bus is a four-lane arrangement with one byte per lane
// (DW = 32) and byte addressing.
module fl_id_probe
    import flprobe_pkg::*;
#(
    parameter int          AW               = 24,
    parameter int          DW               = 32,
    parameter int          SZW              = 32,
    parameter logic [7:0]  CMD_READ_ID      = 8'h90,
    parameter logic [7:0]  CMD_ARRAY        = 8'hFF,
    parameter logic [7:0]  MFR_CODE         = 8'h89,
    parameter logic [7:0]  DEV_BIG_A        = 8'hAA,
    parameter logic [7:0]  DEV_BIG_B        = 8'hA0,
    parameter logic [7:0]  DEV_SMALL        = 8'hA6,
    parameter int unsigned LANE_BIG_BYTES   = 32'h0020_0000,
    parameter int unsigned LANE_SMALL_BYTES = 32'h0010_0000,
    parameter int unsigned LANE_BLOCK_BYTES = 32'h0001_0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic [1:0]     result,
    output logic [SZW-1:0] total_size,
    output logic [SZW-1:0] erase_size,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    output logic           bus_rd,
    output logic           bus_wr,
    input  logic           bus_ready
);

    logic           cmd_valid;
    logic           cmd_write;
    logic [AW-1:0]  cmd_addr;
    logic [DW-1:0]  cmd_wdata;
    logic           cmd_ack;
    logic [DW-1:0]  rsp_data;
    logic [DW-1:0]  mfr_word;
    logic           mfr_ok;
    logic           dev_known;
    logic [SZW-1:0] dec_total;
    logic [SZW-1:0] dec_erase;
    probe_res_e     res_q;

    assign result = res_q;

    flprobe_seq #(
        .AW(AW), .DW(DW), .SZW(SZW),
        .CMD_READ_ID(CMD_READ_ID), .CMD_ARRAY(CMD_ARRAY)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .result(res_q),
        .total_size(total_size), .erase_size(erase_size),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ack(cmd_ack), .rsp_data(rsp_data),
        .mfr_word(mfr_word), .mfr_ok(mfr_ok), .dev_known(dev_known),
        .dec_total(dec_total), .dec_erase(dec_erase)
    );

    flprobe_bus_master #(.AW(AW), .DW(DW)) bm_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ack(cmd_ack), .rsp_data(rsp_data),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready)
    );

    flprobe_id_decode #(
        .DW(DW), .SZW(SZW), .MFR_CODE(MFR_CODE),
        .DEV_BIG_A(DEV_BIG_A), .DEV_BIG_B(DEV_BIG_B), .DEV_SMALL(DEV_SMALL),
        .LANE_BIG_BYTES(LANE_BIG_BYTES), .LANE_SMALL_BYTES(LANE_SMALL_BYTES),
        .LANE_BLOCK_BYTES(LANE_BLOCK_BYTES)
    ) dec_i (
        .mfr_word(mfr_word), .dev_word(rsp_data),
        .mfr_ok(mfr_ok), .dev_known(dev_known),
        .total_bytes(dec_total), .erase_bytes(dec_erase)
    );

endmodule

// File: rtl/flprobe_checker.sv
// Module: flprobe_checker
// Protocol and result properties of the probe, observed at its ports.
// Attached to every fl_id_probe instance by the bind below.
module flprobe_checker #(
    parameter int AW  = 24,
    parameter int DW  = 32,
    parameter int SZW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic [1:0]     result,
    input logic [SZW-1:0] total_size,
    input logic [SZW-1:0] erase_size,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic           bus_rd,
    input logic           bus_wr,
    input logic           bus_ready
);

    // R1: no bus activity while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr));

    // R10: strobes are exclusive.
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R10: a read strobe and its address hold until ready.
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));

    // R10: a write strobe, its address and data hold until ready.
    p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    // R10: the strobe drops the cycle after completion.
    p_strobe_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_ready) |=> (!bus_rd && !bus_wr));

    // R11: done lasts one cycle.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: sizes are zero for any result other than known flash.
    p_size_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != 2'd1) |-> (total_size == '0 && erase_size == '0));

    // R4: a known flash reports non-zero sizes.
    p_known_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd1) |-> (total_size != '0 && erase_size != '0));

endmodule

bind fl_id_probe flprobe_checker #(.AW(AW), .DW(DW), .SZW(SZW)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
    .total_size(total_size), .erase_size(erase_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready)
);

// File: tb/fl_id_probe_tb_top.sv
// Directed bench for fl_id_probe with a behavioural device that acts as a
// flash with an identifier mode, as a RAM, or as a fixed-pattern ROM.
module fl_id_probe_tb_top;

    localparam int AW = 24;
    localparam int DW = 32;
    localparam logic [31:0] FILL = 32'h1357_2468;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done;
    logic [1:0]    result;
    logic [31:0]   total_size, erase_size;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          bus_rd, bus_wr, bus_ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fl_id_probe dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .result(result), .total_size(total_size), .erase_size(erase_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready)
    );

    // Device model settings, written only by the tasks.
    int          kind = 0;          // 0 flash, 1 RAM, 2 ROM
    logic [31:0] mfr_val = '0;
    logic [31:0] dev_val = '0;
    int          lat = 0;
    logic        load_req = 1'b0;
    logic [31:0] load_val = '0;

    // Device state and transfer log, written only by the model.
    logic        id_mode;
    logic [31:0] ram [0:3];
    int          wcnt;
    int          n_ops;
    logic        op_wr   [0:127];
    logic [23:0] op_addr [0:127];
    logic [31:0] op_data [0:127];

    function automatic logic [31:0] dev_read(input logic [23:0] a);
        if (kind == 1) return ram[a[3:2]];
        if (kind == 2) return FILL;
        if (!id_mode)  return FILL;
        if (a == 24'd0) return mfr_val;
        if (a == 24'd4) return dev_val;
        return 32'h0;
    endfunction

    // Device model: answers a strobe after lat wait cycles, logs it.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
            wcnt      <= 0;
            n_ops     <= 0;
            id_mode   <= 1'b0;
        end else begin
            bus_ready <= 1'b0;
            if (load_req) begin
                id_mode <= 1'b0;
                ram[0]  <= load_val;
                ram[1]  <= 32'h0BAD_F00D;
                ram[2]  <= 32'h0;
                ram[3]  <= 32'h0;
            end else if ((bus_rd || bus_wr) && !bus_ready) begin
                if (wcnt >= lat) begin
                    wcnt <= 0;
                    bus_ready <= 1'b1;
                    op_wr[n_ops]   <= bus_wr;
                    op_addr[n_ops] <= bus_addr;
                    op_data[n_ops] <= bus_wr ? bus_wdata : dev_read(bus_addr);
                    n_ops <= n_ops + 1;
                    if (bus_wr) begin
                        if (kind == 1) ram[bus_addr[3:2]] <= bus_wdata;
                        if (kind == 0 && bus_wdata == 32'h9090_9090) id_mode <= 1'b1;
                        if (kind == 0 && bus_wdata == 32'hFFFF_FFFF) id_mode <= 1'b0;
                    end else begin
                        bus_rdata <= dev_read(bus_addr);
                    end
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Results of the last probe.
    logic [1:0]  got_res;
    logic [31:0] got_total, got_erase;
    logic        got_done_after;
    int          base;
    int          nops;

    task automatic do_probe(input int k, input logic [31:0] m, input logic [31:0] d,
                            input int l, input logic [31:0] ram0, input bit extra_start);
        bit seen = 0;
        @(negedge clk);
        kind = k; mfr_val = m; dev_val = d; lat = l; load_val = ram0; load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        base = n_ops;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done) begin
                seen = 1;
                break;
            end
            start = (extra_start && i == 6);
            @(negedge clk);
        end
        start = 1'b0;
        if (!seen) begin
            checks++; errors++;
            $display("FAIL R11: done never seen, actual 0 expected 1");
        end
        got_res = result; got_total = total_size; got_erase = erase_size;
        @(negedge clk);
        got_done_after = done;
        repeat (20) @(negedge clk);
        nops = n_ops - base;
    endtask

    task automatic check_flash_sequence(input string tag);
        chk({"R2 ", tag, " op0 is read"},  64'(op_wr[base]), 64'd0);
        chk({"R2 ", tag, " op0 addr"},     64'(op_addr[base]), 64'd0);
        chk({"R2 ", tag, " op1 is write"}, 64'(op_wr[base+1]), 64'd1);
        chk({"R2 ", tag, " op1 data"},     64'(op_data[base+1]), 64'h9090_9090);
        chk({"R3 ", tag, " op2 read addr"}, 64'(op_addr[base+2]), 64'd0);
        chk({"R3 ", tag, " op3 read addr"}, 64'(op_addr[base+3]), 64'd4);
        chk({"R3 ", tag, " op3 is read"},  64'(op_wr[base+3]), 64'd0);
        chk({"R7 ", tag, " op count"},     64'(nops), 64'd5);
        chk({"R7 ", tag, " last is write"}, 64'(op_wr[base+4]), 64'd1);
        chk({"R7 ", tag, " last addr"},    64'(op_addr[base+4]), 64'd0);
        chk({"R7 ", tag, " last data"},    64'(op_data[base+4]), 64'hFFFF_FFFF);
    endtask

    task automatic t_reset;
        chk("R1 done",   64'(done),   64'd0);
        chk("R1 busy",   64'(busy),   64'd0);
        chk("R1 rd",     64'(bus_rd), 64'd0);
        chk("R1 wr",     64'(bus_wr), 64'd0);
        chk("R1 result", 64'(result), 64'd0);
    endtask

    task automatic t_big_a;
        do_probe(0, 32'h8989_8989, 32'hAAAA_AAAA, 0, 32'h0, 0);
        chk("R4 big A result", 64'(got_res), 64'd1);
        chk("R4 big A total",  64'(got_total), 64'h0080_0000);
        chk("R4 big A erase",  64'(got_erase), 64'h0004_0000);
        check_flash_sequence("big A");
        chk("R11 done one cycle", 64'(got_done_after), 64'd0);
    endtask

    task automatic t_big_b_wait;
        do_probe(0, 32'h8989_8989, 32'hA0A0_A0A0, 2, 32'h0, 0);
        chk("R4 big B result", 64'(got_res), 64'd1);
        chk("R4 big B total",  64'(got_total), 64'h0080_0000);
        chk("R10 wait-state op count", 64'(nops), 64'd5);
        check_flash_sequence("big B waits");
    endtask

    task automatic t_small;
        do_probe(0, 32'h8989_8989, 32'hA6A6_A6A6, 1, 32'h0, 0);
        chk("R5 small result", 64'(got_res), 64'd1);
        chk("R5 small total",  64'(got_total), 64'h0040_0000);
        chk("R5 small erase",  64'(got_erase), 64'h0004_0000);
    endtask

    task automatic t_unknown;
        do_probe(0, 32'h8989_8989, 32'h1212_1212, 0, 32'h0, 0);
        chk("R6 unknown result", 64'(got_res), 64'd2);
        chk("R6 unknown total",  64'(got_total), 64'd0);
        chk("R6 unknown erase",  64'(got_erase), 64'd0);
        check_flash_sequence("unknown");
    endtask

    task automatic t_ram;
        do_probe(1, 32'h0, 32'h0, 0, 32'h5A5A_0F0F, 0);
        chk("R8 ram result",     64'(got_res), 64'd3);
        chk("R8 ram total",      64'(got_total), 64'd0);
        chk("R8 ram op count",   64'(nops), 64'd6);
        chk("R8 recheck is read", 64'(op_wr[base+4]), 64'd0);
        chk("R8 recheck addr",   64'(op_addr[base+4]), 64'd0);
        chk("R8 restore is write", 64'(op_wr[base+5]), 64'd1);
        chk("R8 restore addr",   64'(op_addr[base+5]), 64'd0);
        chk("R8 restore data",   64'(op_data[base+5]), 64'h5A5A_0F0F);
        chk("R8 ram word 0 kept", 64'(ram[0]), 64'h5A5A_0F0F);
    endtask

    task automatic t_rom;
        int writes = 0;
        do_probe(2, 32'h0, 32'h0, 0, 32'h0, 0);
        for (int i = 0; i < nops; i++) writes += int'(op_wr[base+i]);
        chk("R9 rom result",   64'(got_res), 64'd0);
        chk("R9 rom op count", 64'(nops), 64'd5);
        chk("R9 rom writes",   64'(writes), 64'd1);
    endtask

    task automatic t_one_lane_off;
        do_probe(0, 32'h8989_8988, 32'hAAAA_AAAA, 0, 32'h0, 0);
        chk("R9 partial maker result", 64'(got_res), 64'd0);
        chk("R9 partial maker total",  64'(got_total), 64'd0);
        chk("R9 partial maker ops",    64'(nops), 64'd5);
    endtask

    task automatic t_start_busy;
        do_probe(0, 32'h8989_8989, 32'hAAAA_AAAA, 3, 32'h0, 1);
        chk("R11 busy start result", 64'(got_res), 64'd1);
        chk("R11 busy start ignored ops", 64'(nops), 64'd5);
        chk("R11 idle after run", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_big_a();
        t_big_b_wait();
        t_small();
        t_unknown();
        t_ram();
        t_rom();
        t_one_lane_off();
        t_start_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule